// File: doc/BRIEF.md
# Masked Block-Write Data Path

This block sits between the cycle decoder of a 16-bit-wide video DRAM and its row buffer. It produces the column enables, the per-bit write enables and the write data for each write. It holds two 16-bit registers: a colour register and a write-mask register. Each write is presented for one clock with its decoded cycle kind, two mode flags, a column address, and two data bus values. One bus value is captured when the row strobe falls and one when the column strobe falls.

A normal write puts the column-time data on one column. A block write covers four adjacent columns. The colour register value is copied to every column that a four-bit column mask enables. The column mask comes from the low data bus bits at column time. The per-bit enables can come from three sources. An unmasked cycle enables all bits. A masked cycle in non-persistent mode uses the row-time bus value. A masked cycle in persistent mode uses the stored write-mask register and ignores the row-time bus.

Every result is registered. The row buffer sees a single-clock write strobe one cycle after the cycle is presented. The strobe comes with a column-group base address, a four-lane column enable, sixteen bit enables and the data.

Top module: `bwr_top`

## Requirements
- R1: After reset `wr_en`, `col_en`, `bit_en` and `wr_data` are zero, and both the colour and write-mask registers hold zero.
- R2: A cycle of kind 1 (write) gives `wr_data` equal to `col_dq`. It sets `col_base` to `col_addr` with bits 1:0 cleared, and `col_en` to the one-hot lane `col_addr[1:0]`.
- R3: A cycle of kind 2 (block write) gives `col_base` equal to `col_addr` with bits 1:0 cleared and `col_en` equal to `col_dq[3:0]`. Bit i enables column base+i. `wr_data` equals the colour register.
- R4: A write or block write with `masked` low drives `bit_en` to all ones.
- R5: A write or block write with `masked` high and `persist` low drives `bit_en` to the value of `row_dq` from that cycle.
- R6: A write or block write with `masked` high and `persist` high drives `bit_en` to the write-mask register, whatever `row_dq` holds.
- R7: A cycle of kind 4 (load colour) stores `col_dq` in the colour register and raises no write enable. No other kind changes that register.
- R8: A cycle of kind 3 (load mask) stores `col_dq` in the write-mask register and raises no write enable. No other kind changes that register.
- R9: `wr_en` is high for exactly the one clock after each write or block write cycle. Whenever it is low, `col_en` and `bit_en` are zero. Kind 0 and the unused codes 5 to 7 write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_kind | input | 3 | Decoded cycle kind: 0 idle, 1 write, 2 block write, 3 load mask, 4 load colour |
| masked | input | 1 | Write-per-bit masking requested for this cycle |
| persist | input | 1 | Persistent mask mode is active |
| row_dq | input | 16 | Data bus value captured at row strobe fall |
| col_dq | input | 16 | Data bus value captured at column strobe fall |
| col_addr | input | 9 | Latched column address; bits 8:2 form the block address |
| wr_en | output | 1 | One-clock write strobe |
| col_base | output | 9 | Base column of the four-column group |
| col_en | output | 4 | Column enables for lanes base+0 to base+3 |
| bit_en | output | 16 | Per-bit write enables |
| wr_data | output | 16 | Data to write into each enabled column |

## Verification
Every output is due on the first clock edge after the cycle is presented. The bench drives each cycle on a falling edge, holds it across one rising edge, and compares all outputs at the next falling edge. One falling edge later it confirms that the strobe and enables have dropped. A register load becomes visible one edge after the load cycle. For that reason a following block write is checked for the new colour or mask, and no earlier cycle is checked for it.

// File: rtl/bwr_pkg.sv
package bwr_pkg;

    typedef enum logic [2:0] {
        CK_IDLE    = 3'd0,
        CK_WRITE   = 3'd1,
        CK_BLOCK   = 3'd2,
        CK_LDMASK  = 3'd3,
        CK_LDCOLOR = 3'd4
    } cyc_kind_e;

    function automatic logic kind_writes(input logic [2:0] k);
        return (k == CK_WRITE) || (k == CK_BLOCK);
    endfunction

endpackage

// File: rtl/bwr_hold_regs.sv
module bwr_hold_regs #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    kind,
    input  logic [DW-1:0] col_dq,
    output logic [DW-1:0] colour_q,
    output logic [DW-1:0] wmask_q
);
    import bwr_pkg::*;

    typedef struct packed {
        logic [DW-1:0] colour;
        logic [DW-1:0] wmask;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        case (kind)
            CK_LDMASK:  hold_d.wmask  = col_dq;
            CK_LDCOLOR: hold_d.colour = col_dq;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign colour_q = hold_q.colour;
    assign wmask_q  = hold_q.wmask;

    a_r7_colour_load: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CK_LDCOLOR) |=> (colour_q == $past(col_dq)));
    a_r7_colour_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != CK_LDCOLOR) |=> $stable(colour_q));
    a_r8_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CK_LDMASK) |=> (wmask_q == $past(col_dq)));
    a_r8_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != CK_LDMASK) |=> $stable(wmask_q));

endmodule

// File: rtl/bwr_mask_pick.sv
module bwr_mask_pick #(
    parameter int DW = 16
) (
    input  logic          masked,
    input  logic          persist,
    input  logic [DW-1:0] row_dq,
    input  logic [DW-1:0] wmask_q,
    output logic [DW-1:0] bit_sel
);
    always_comb begin
        if (!masked)      bit_sel = '1;
        else if (persist) bit_sel = wmask_q;
        else              bit_sel = row_dq;
    end
endmodule

// File: rtl/bwr_lane_dec.sv
module bwr_lane_dec #(
    parameter int LANES   = 4,
    parameter int LANE_AW = $clog2(LANES)
) (
    input  logic               is_block,
    input  logic [LANE_AW-1:0] addr_lo,
    input  logic [LANES-1:0]   colmask,
    output logic [LANES-1:0]   lane_en
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_en[i] = is_block ? colmask[i]
                                     : (addr_lo == LANE_AW'(i));
    end
endmodule

// File: rtl/bwr_top.sv
module bwr_top #(
    parameter int DW    = 16,
    parameter int AW    = 9,
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cyc_kind,
    input  logic             masked,
    input  logic             persist,
    input  logic [DW-1:0]    row_dq,
    input  logic [DW-1:0]    col_dq,
    input  logic [AW-1:0]    col_addr,
    output logic             wr_en,
    output logic [AW-1:0]    col_base,
    output logic [LANES-1:0] col_en,
    output logic [DW-1:0]    bit_en,
    output logic [DW-1:0]    wr_data
);
    import bwr_pkg::*;

    localparam int LANE_AW = $clog2(LANES);

    typedef struct packed {
        logic             wr;
        logic [AW-1:0]    base;
        logic [LANES-1:0] en;
        logic [DW-1:0]    bits;
        logic [DW-1:0]    data;
    } out_t;

    logic [DW-1:0]    colour_q, wmask_q, bit_sel;
    logic [LANES-1:0] lane_en;
    logic             is_block, is_write;
    out_t             out_d, out_q;

    assign is_block = (cyc_kind == CK_BLOCK);
    assign is_write = kind_writes(cyc_kind);

    bwr_hold_regs #(.DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .kind     (cyc_kind),
        .col_dq   (col_dq),
        .colour_q (colour_q),
        .wmask_q  (wmask_q)
    );

    bwr_mask_pick #(.DW(DW)) u_pick (
        .masked  (masked),
        .persist (persist),
        .row_dq  (row_dq),
        .wmask_q (wmask_q),
        .bit_sel (bit_sel)
    );

    bwr_lane_dec #(.LANES(LANES), .LANE_AW(LANE_AW)) u_lane (
        .is_block (is_block),
        .addr_lo  (col_addr[LANE_AW-1:0]),
        .colmask  (col_dq[LANES-1:0]),
        .lane_en  (lane_en)
    );

    always_comb begin
        out_d = '0;
        if (is_write) begin
            out_d.wr   = 1'b1;
            out_d.base = {col_addr[AW-1:LANE_AW], LANE_AW'(0)};
            out_d.en   = lane_en;
            out_d.bits = bit_sel;
            out_d.data = is_block ? colour_q : col_dq;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign wr_en    = out_q.wr;
    assign col_base = out_q.base;
    assign col_en   = out_q.en;
    assign bit_en   = out_q.bits;
    assign wr_data  = out_q.data;

    a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> (col_en == '0 && bit_en == '0));
    a_r9_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !kind_writes(cyc_kind) |=> !wr_en);
    a_r2_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_kind == CK_WRITE) |=>
            (wr_en && $countones(col_en) == 1 && wr_data == $past(col_dq)));
    a_r3_block_colour: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_kind == CK_BLOCK) |=> (wr_en && wr_data == $past(colour_q)));
    a_r4_all_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_writes(cyc_kind) && !masked) |=> (bit_en == '1));
    a_r5_row_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_writes(cyc_kind) && masked && !persist) |=> (bit_en == $past(row_dq)));
    a_r6_stored_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_writes(cyc_kind) && masked && persist) |=> (bit_en == $past(wmask_q)));

endmodule

// File: tb/bwr_top_test.sv
module bwr_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cyc_kind = 3'd0;
    logic        masked = 1'b0;
    logic        persist = 1'b0;
    logic [15:0] row_dq = '0;
    logic [15:0] col_dq = '0;
    logic [8:0]  col_addr = '0;
    logic        wr_en;
    logic [8:0]  col_base;
    logic [3:0]  col_en;
    logic [15:0] bit_en;
    logic [15:0] wr_data;

    int compared = 0;
    int mismatched = 0;

    always #4 clk = ~clk;

    bwr_top uut (
        .clk(clk), .rst_n(rst_n), .cyc_kind(cyc_kind), .masked(masked),
        .persist(persist), .row_dq(row_dq), .col_dq(col_dq),
        .col_addr(col_addr), .wr_en(wr_en), .col_base(col_base),
        .col_en(col_en), .bit_en(bit_en), .wr_data(wr_data)
    );

    task automatic check(input string req, input logic w, input logic [8:0] b,
                         input logic [3:0] e, input logic [15:0] bits,
                         input logic [15:0] d);
        compared++;
        if ({wr_en, col_base, col_en, bit_en, wr_data} !== {w, b, e, bits, d}) begin
            mismatched++;
            $display("FAIL %s: got wr=%b base=%h en=%b bits=%h data=%h, want wr=%b base=%h en=%b bits=%h data=%h",
                     req, wr_en, col_base, col_en, bit_en, wr_data, w, b, e, bits, d);
        end
    endtask

    task automatic check_idle(input string req);
        @(negedge clk);
        compared++;
        if (wr_en !== 1'b0 || col_en !== 4'h0 || bit_en !== 16'h0) begin
            mismatched++;
            $display("FAIL %s: got wr=%b en=%b bits=%h, want wr=0 en=0000 bits=0000",
                     req, wr_en, col_en, bit_en);
        end
    endtask

    task automatic run_cyc(input logic [2:0] k, input logic m, input logic p,
                           input logic [15:0] r, input logic [15:0] c,
                           input logic [8:0] a);
        @(negedge clk);
        cyc_kind = k; masked = m; persist = p; row_dq = r; col_dq = c; col_addr = a;
        @(negedge clk);
        cyc_kind = 3'd0; masked = 1'b0; persist = 1'b0;
        row_dq = 16'hDEAD; col_dq = 16'hBEEF; col_addr = 9'h155;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check("R1 reset outputs", 1'b0, 9'h0, 4'h0, 16'h0, 16'h0);
        rst_n = 1'b1;
        run_cyc(3'd2, 1'b0, 1'b0, 16'h0, 16'h000F, 9'h000);
        check("R1 colour zero after reset", 1'b1, 9'h000, 4'hF, 16'hFFFF, 16'h0000);
        run_cyc(3'd2, 1'b1, 1'b1, 16'hFFFF, 16'h0003, 9'h008);
        check("R1 mask zero after reset", 1'b1, 9'h008, 4'h3, 16'h0000, 16'h0000);
    endtask

    task automatic t_normal_write;
        run_cyc(3'd1, 1'b0, 1'b0, 16'h1111, 16'hBEEF, 9'h1A7);
        check("R2 R4 normal write", 1'b1, 9'h1A4, 4'b1000, 16'hFFFF, 16'hBEEF);
        check_idle("R9 strobe drops after write");
        run_cyc(3'd1, 1'b0, 1'b0, 16'h0, 16'h0042, 9'h0C1);
        check("R2 lane one", 1'b1, 9'h0C0, 4'b0010, 16'hFFFF, 16'h0042);
    endtask

    task automatic t_block_write;
        run_cyc(3'd4, 1'b0, 1'b0, 16'h0, 16'h5A3C, 9'h0);
        check("R7 load colour no write", 1'b0, 9'h0, 4'h0, 16'h0, 16'h0);
        run_cyc(3'd2, 1'b0, 1'b0, 16'h0, 16'hFFFA, 9'h0F3);
        check("R3 R4 block write", 1'b1, 9'h0F0, 4'b1010, 16'hFFFF, 16'h5A3C);
        check_idle("R9 strobe drops after block");
        run_cyc(3'd1, 1'b0, 1'b0, 16'h0, 16'h7777, 9'h003);
        run_cyc(3'd2, 1'b0, 1'b0, 16'h0, 16'h0005, 9'h1FF);
        check("R7 colour unchanged by write", 1'b1, 9'h1FC, 4'b0101, 16'hFFFF, 16'h5A3C);
    endtask

    task automatic t_masks;
        run_cyc(3'd1, 1'b1, 1'b0, 16'h00FF, 16'h1234, 9'h005);
        check("R5 row mask on write", 1'b1, 9'h004, 4'b0010, 16'h00FF, 16'h1234);
        run_cyc(3'd3, 1'b0, 1'b0, 16'h0, 16'hF0F0, 9'h0);
        check("R8 load mask no write", 1'b0, 9'h0, 4'h0, 16'h0, 16'h0);
        run_cyc(3'd2, 1'b1, 1'b1, 16'h0F0F, 16'h0001, 9'h020);
        check("R6 stored mask on block", 1'b1, 9'h020, 4'b0001, 16'hF0F0, 16'h5A3C);
        run_cyc(3'd1, 1'b1, 1'b1, 16'h0000, 16'hCAFE, 9'h002);
        check("R6 stored mask on write", 1'b1, 9'h000, 4'b0100, 16'hF0F0, 16'hCAFE);
        run_cyc(3'd2, 1'b1, 1'b0, 16'h3333, 16'h000C, 9'h044);
        check("R5 row mask on block", 1'b1, 9'h044, 4'b1100, 16'h3333, 16'h5A3C);
        run_cyc(3'd3, 1'b0, 1'b0, 16'h0, 16'h0101, 9'h0);
        run_cyc(3'd2, 1'b1, 1'b1, 16'hFFFF, 16'h000F, 9'h100);
        check("R8 reloaded mask", 1'b1, 9'h100, 4'hF, 16'h0101, 16'h5A3C);
    endtask

    task automatic t_unused_kinds;
        for (int k = 5; k < 8; k++) begin
            run_cyc(3'(k), 1'b1, 1'b0, 16'hFFFF, 16'hFFFF, 9'h1FF);
            check("R9 unused kind no write", 1'b0, 9'h0, 4'h0, 16'h0, 16'h0);
        end
        run_cyc(3'd2, 1'b0, 1'b0, 16'h0, 16'h0008, 9'h010);
        check("R7 R9 colour kept across unused kinds", 1'b1, 9'h010, 4'b1000, 16'hFFFF, 16'h5A3C);
    endtask

    initial begin
        #1_000_000;
        mismatched++;
        $display("FAIL watchdog: got timeout, want completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        t_reset();
        t_normal_write();
        t_block_write();
        t_masks();
        t_unused_kinds();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule